// File: doc/BRIEF.md
# Nested Interrupt Level Controller

This block collects a set of peripheral interrupt sources and reduces them to a single encoded urgency level for a processor core. Each source input has a level assigned at build time. The block captures each rising edge of a source into a pending bit. It drops pending sources whose mask bit is set. The highest level among the rest is presented on a registered level bus, together with a single request line. Software can read the same level from a register.

When the handler for a level begins, software writes that level to an acknowledge register. From then on the block stays silent for that level and every level below it, so only a more urgent source can interrupt the handler. A completion write releases the most recent level and restores the threshold that was in force before it. Levels can nest this way up to the top level.

Registers are reached through a plain single-cycle port. A write takes effect on the clock edge. Read data is combinational from the current address. Level 0 means "no request".

Top module: `ilc_level_ctrl`

## Requirements
- R1: After reset, all pending bits are 0, all mask bits are 1, no level is in service, and the level output, request line and threshold read as 0.
- R2: A 0-to-1 transition of a source input sets its pending bit (address 1). A source held high does not set the bit again after it has been cleared.
- R3: Writing 1 to a bit of the pending register (address 1) clears that bit. If a new rising edge arrives in the same cycle, the set wins.
- R4: The status register (address 0) returns the source inputs as registered one cycle earlier, regardless of mask and pending state.
- R5: The mask register (address 2) is read/write, and a 1 blocks the matching source. A masked source still records pending.
- R6: The selected level is the highest assigned level among pending, unmasked sources, or 0 if there is none. Source 0 and source 1 both have level 1, and source i has level i for i from 2 to 7.
- R7: The level output is registered. It reflects the register state before the most recent clock edge, and the level register (address 3, bits 2:0) reads the same value.
- R8: The request line is high exactly when the level output is non-zero.
- R9: A write of level v to the acknowledge register (address 4, bits 2:0) puts v in service if v is above the current threshold. The threshold (address 6, bits 2:0) becomes v, and levels at or below v are no longer presented.
- R10: An acknowledge write whose level is 0 or not above the current threshold is ignored.
- R11: A write to the completion register (address 5) removes the highest level in service and restores the previous threshold. On an empty in-service state it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | N_SRC | Raw interrupt source inputs |
| reg_wen_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | N_SRC | Register write data |
| reg_rdata_o | output | N_SRC | Register read data for reg_addr_i |
| irq_o | output | 1 | Interrupt request to the core |
| irq_level_o | output | LVL_W | Encoded active level, 0 for none |

## Verification
The bench targets the corner cases where an error would be easy to miss. A pending clear that lands in the same cycle as a new edge would lose the interrupt if the clear won. An acknowledge at or below the current threshold would wrongly lower or corrupt the threshold if it were not ignored. A completion write with nothing in service would underflow the nesting state. A source held high after its pending bit is cleared would fire again if the block sensed levels instead of edges. The bench also checks the one-cycle lag of the registered level after each acknowledge and completion, and two sources sharing level 1. Long random runs mix all of these against a bench-side model.

// File: rtl/ilc_pkg.sv
package ilc_pkg;
  localparam int ILC_N_SRC  = 8;
  localparam int ILC_LVL_W  = 3;
  localparam int ILC_ADDR_W = 3;

  localparam logic [ILC_ADDR_W-1:0] A_STATUS = 3'd0;
  localparam logic [ILC_ADDR_W-1:0] A_PEND   = 3'd1;
  localparam logic [ILC_ADDR_W-1:0] A_MASK   = 3'd2;
  localparam logic [ILC_ADDR_W-1:0] A_LEVEL  = 3'd3;
  localparam logic [ILC_ADDR_W-1:0] A_ACK    = 3'd4;
  localparam logic [ILC_ADDR_W-1:0] A_DONE   = 3'd5;
  localparam logic [ILC_ADDR_W-1:0] A_THRESH = 3'd6;
endpackage

// File: rtl/ilc_capture.sv
module ilc_capture #(
  parameter int N_SRC = ilc_pkg::ILC_N_SRC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] clr_i,
  input  logic             mask_we_i,
  input  logic [N_SRC-1:0] mask_d_i,
  output logic [N_SRC-1:0] status_o,
  output logic [N_SRC-1:0] pend_o,
  output logic [N_SRC-1:0] mask_o,
  output logic [N_SRC-1:0] elig_o
);
  logic [N_SRC-1:0] src_q, pend_q, mask_q, rise;

  assign rise = src_i & ~src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      pend_q <= '0;
      mask_q <= '1;
    end else begin
      src_q  <= src_i;
      pend_q <= (pend_q & ~clr_i) | rise;
      if (mask_we_i) mask_q <= mask_d_i;
    end
  end

  assign status_o = src_q;
  assign pend_o   = pend_q;
  assign mask_o   = mask_q;
  assign elig_o   = pend_q & ~mask_q;

  assert_edge_sets_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((pend_q & $past(rise)) == $past(rise)));

  assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~rise)) |=> ((pend_q & $past(clr_i & ~rise)) == '0));
endmodule

// File: rtl/ilc_encoder.sv
module ilc_encoder #(
  parameter int N_SRC = ilc_pkg::ILC_N_SRC,
  parameter int LVL_W = ilc_pkg::ILC_LVL_W,
  parameter logic [N_SRC*LVL_W-1:0] SRC_LEVELS = '0
) (
  input  logic [N_SRC-1:0] elig_i,
  input  logic [LVL_W-1:0] thresh_i,
  output logic [LVL_W-1:0] level_o
);
  localparam int NLVL = 1 << LVL_W;

  logic [NLVL-1:0]  req;
  logic [LVL_W-1:0] best;

  // collect requests per level
  generate
    for (genvar l = 0; l < NLVL; l++) begin : g_lvl
      logic [N_SRC-1:0] hit;
      for (genvar i = 0; i < N_SRC; i++) begin : g_src
        if (l == 0) begin : g_none
          assign hit[i] = 1'b0;
        end else begin : g_cmp
          assign hit[i] = elig_i[i] &&
                          (SRC_LEVELS[i*LVL_W +: LVL_W] == LVL_W'(l));
        end
      end
      assign req[l] = |hit;
    end
  endgenerate

  // priority encode: highest level wins
  always_comb begin
    best = '0;
    for (int l = 1; l < NLVL; l++) begin
      if (req[l]) best = LVL_W'(l);
    end
  end

  assign level_o = (best > thresh_i) ? best : '0;
endmodule

// File: rtl/ilc_inservice.sv
module ilc_inservice #(
  parameter int LVL_W = ilc_pkg::ILC_LVL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_en_i,
  input  logic [LVL_W-1:0] ack_lvl_i,
  input  logic             done_en_i,
  output logic [LVL_W-1:0] thresh_o
);
  localparam int NLVL = 1 << LVL_W;

  // one bit per level; nested levels are strictly increasing, so the
  // highest set bit is the top of the nesting stack
  logic [NLVL-1:0]  isr_q;
  logic [LVL_W-1:0] top;

  always_comb begin
    top = '0;
    for (int l = 1; l < NLVL; l++) begin
      if (isr_q[l]) top = LVL_W'(l);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= '0;
    end else if (ack_en_i && (ack_lvl_i > top)) begin
      isr_q[ack_lvl_i] <= 1'b1;
    end else if (done_en_i && (top != '0)) begin
      isr_q[top] <= 1'b0;
    end
  end

  assign thresh_o = top;

  assert_no_level0_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (isr_q[0] == 1'b0));

  assert_ack_push_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_en_i && (ack_lvl_i > top)) |=> (thresh_o == $past(ack_lvl_i)));

  assert_ack_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_en_i && (ack_lvl_i <= top)) |=> $stable(isr_q));

  assert_done_pops_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done_en_i && (top != '0)) |=> (thresh_o < $past(top)));

  assert_done_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done_en_i && (top == '0)) |=> (isr_q == '0));
endmodule

// File: rtl/ilc_level_ctrl.sv
module ilc_level_ctrl #(
  parameter int N_SRC = ilc_pkg::ILC_N_SRC,
  parameter int LVL_W = ilc_pkg::ILC_LVL_W,
  parameter logic [N_SRC*LVL_W-1:0] SRC_LEVELS =
    {3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd1}
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_SRC-1:0]               src_i,
  input  logic                           reg_wen_i,
  input  logic [ilc_pkg::ILC_ADDR_W-1:0] reg_addr_i,
  input  logic [N_SRC-1:0]               reg_wdata_i,
  output logic [N_SRC-1:0]               reg_rdata_o,
  output logic                           irq_o,
  output logic [LVL_W-1:0]               irq_level_o
);
  import ilc_pkg::*;

  localparam int PAD_W = N_SRC - LVL_W;

  logic [N_SRC-1:0] status, pend, mask, elig, clr;
  logic             mask_we, ack_en, done_en;
  logic [LVL_W-1:0] thresh, level_d, level_q;
  logic             irq_q;

  assign clr     = (reg_wen_i && reg_addr_i == A_PEND) ? reg_wdata_i : '0;
  assign mask_we = reg_wen_i && (reg_addr_i == A_MASK);
  assign ack_en  = reg_wen_i && (reg_addr_i == A_ACK);
  assign done_en = reg_wen_i && (reg_addr_i == A_DONE);

  ilc_capture #(.N_SRC(N_SRC)) u_capture (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .clr_i(clr),
    .mask_we_i(mask_we), .mask_d_i(reg_wdata_i),
    .status_o(status), .pend_o(pend), .mask_o(mask), .elig_o(elig)
  );

  ilc_encoder #(.N_SRC(N_SRC), .LVL_W(LVL_W), .SRC_LEVELS(SRC_LEVELS)) u_enc (
    .elig_i(elig), .thresh_i(thresh), .level_o(level_d)
  );

  ilc_inservice #(.LVL_W(LVL_W)) u_isr (
    .clk(clk), .rst_n(rst_n), .ack_en_i(ack_en),
    .ack_lvl_i(reg_wdata_i[LVL_W-1:0]), .done_en_i(done_en),
    .thresh_o(thresh)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      level_q <= level_d;
      irq_q   <= (level_d != '0);
    end
  end

  assign irq_level_o = level_q;
  assign irq_o       = irq_q;

  always_comb begin
    case (reg_addr_i)
      A_STATUS: reg_rdata_o = status;
      A_PEND:   reg_rdata_o = pend;
      A_MASK:   reg_rdata_o = mask;
      A_LEVEL:  reg_rdata_o = {{PAD_W{1'b0}}, level_q};
      A_THRESH: reg_rdata_o = {{PAD_W{1'b0}}, thresh};
      default:  reg_rdata_o = '0;
    endcase
  end

  assert_irq_matches_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (irq_level_o != '0));

  assert_above_threshold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irq_level_o == '0) || (irq_level_o > $past(thresh))));

  assert_masked_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (elig == '0) |=> (irq_level_o == '0));
endmodule

// File: tb/ilc_level_ctrl_tb.sv
`timescale 1ns/1ps
module ilc_level_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] src = '0;
  logic       wen = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;
  logic [2:0] lvl;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [7:0] m_srcq = '0, m_pend = '0, m_mask = '1, m_isr = '0;
  logic [2:0] m_lvl = '0;

  always #4 clk = ~clk;

  ilc_level_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .reg_wen_i(wen),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_o(irq), .irq_level_o(lvl)
  );

  function automatic logic [2:0] lvl_of(int i);
    return (i == 0) ? 3'd1 : 3'(i);
  endfunction

  function automatic logic [2:0] top_of(logic [7:0] v);
    logic [2:0] t = '0;
    for (int l = 1; l < 8; l++) if (v[l]) t = 3'(l);
    return t;
  endfunction

  function automatic logic [2:0] select(logic [7:0] p, logic [7:0] m, logic [7:0] isr);
    logic [2:0] b = '0;
    for (int i = 0; i < 8; i++)
      if (p[i] && !m[i] && lvl_of(i) > b) b = lvl_of(i);
    return (b > top_of(isr)) ? b : 3'd0;
  endfunction

  function automatic logic [7:0] exp_rd(logic [2:0] a);
    case (a)
      3'd0: return m_srcq;
      3'd1: return m_pend;
      3'd2: return m_mask;
      3'd3: return {5'd0, m_lvl};
      3'd6: return {5'd0, top_of(m_isr)};
      default: return 8'd0;
    endcase
  endfunction

  function automatic string rd_req(logic [2:0] a);
    case (a)
      3'd0: return "R4";
      3'd1: return "R2/R3";
      3'd2: return "R5";
      3'd3: return "R7";
      3'd6: return "R9/R11";
      default: return "R1";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    check(lvl == m_lvl, "R6/R7 level", lvl, m_lvl);
    check(irq == (m_lvl != 0), "R8 irq", irq, m_lvl != 0);
    check(rdata == exp_rd(addr), rd_req(addr), rdata, exp_rd(addr));
  endtask

  task automatic step(input logic [7:0] s, input logic w, input logic [2:0] a,
                      input logic [7:0] d);
    logic [2:0] nl;
    logic [7:0] rise, clr;
    @(negedge clk);
    src = s; wen = w; addr = a; wdata = d;
    nl   = select(m_pend, m_mask, m_isr);
    rise = s & ~m_srcq;
    clr  = (w && a == 3'd1) ? d : 8'd0;
    m_pend = (m_pend & ~clr) | rise;
    if (w && a == 3'd2) m_mask = d;
    if (w && a == 3'd4 && d[2:0] > top_of(m_isr)) m_isr[d[2:0]] = 1'b1;
    else if (w && a == 3'd5 && top_of(m_isr) != 0) m_isr[top_of(m_isr)] = 1'b0;
    m_srcq = s;
    m_lvl  = nl;
    @(posedge clk);
    #1;
    compare_all();
  endtask

  task automatic rd(input logic [2:0] a);
    step(src, 1'b0, a, 8'd0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    #20;
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state
    #1;
    check(lvl == 0 && irq == 0, "R1 outputs", {irq, lvl}, 0);
    rd(3'd2); check(rdata == 8'hff, "R1 mask", rdata, 8'hff);
    rd(3'd1); check(rdata == 8'h00, "R1 pend", rdata, 0);
    rd(3'd6); check(rdata == 8'h00, "R1 thresh", rdata, 0);

    step(8'h00, 1'b1, 3'd2, 8'h00);                 // unmask all (R5)
    // R2 / R7: one edge, registered level one cycle later
    step(8'h08, 1'b0, 3'd3, 8'h00);
    check(lvl == 0, "R7 lag", lvl, 0);
    step(8'h08, 1'b0, 3'd3, 8'h00);
    check(lvl == 3, "R6 level3", lvl, 3);
    // R6: highest of several
    step(8'ha8, 1'b0, 3'd0, 8'h00);
    step(8'ha8, 1'b0, 3'd3, 8'h00);
    check(lvl == 7, "R6 level7", lvl, 7);
    // R9: acknowledge 7 suppresses levels up to 7
    step(8'ha8, 1'b1, 3'd4, 8'h07);
    step(8'ha8, 1'b0, 3'd6, 8'h00);
    check(rdata == 8'd7 && lvl == 0, "R9 thresh7", {rdata, 5'd0, lvl}, 16'h0700);
    // R10: lower and zero acknowledge ignored
    step(8'ha8, 1'b1, 3'd4, 8'h05);
    step(8'ha8, 1'b1, 3'd4, 8'h00);
    rd(3'd6); check(rdata == 8'd7, "R10 ignored", rdata, 7);
    // R11: completion restores, then empty completion ignored
    step(8'ha8, 1'b1, 3'd5, 8'h00);
    step(8'ha8, 1'b1, 3'd5, 8'h00);
    rd(3'd6); check(rdata == 8'd0 && lvl == 7, "R11 restore", {rdata, 5'd0, lvl}, 7);
    // nested: ack 3 then 5, done returns to 3
    step(8'ha8, 1'b1, 3'd4, 8'h03);
    step(8'ha8, 1'b1, 3'd4, 8'h05);
    step(8'ha8, 1'b1, 3'd5, 8'h00);
    rd(3'd6); check(rdata == 8'd3, "R11 nested", rdata, 3);
    step(8'ha8, 1'b1, 3'd5, 8'h00);
    // R5 / R4: mask source 7, status still raw
    step(8'ha8, 1'b1, 3'd2, 8'h80);
    rd(3'd0); check(rdata == 8'ha8, "R4 status", rdata, 8'ha8);
    check(lvl == 5, "R5 masked", lvl, 5);
    // R2: clear while held high stays clear
    step(8'ha8, 1'b1, 3'd1, 8'h80);
    rd(3'd1); check(rdata[7] == 1'b0, "R2 held", rdata[7], 0);
    // R3: clear with simultaneous edge: set wins
    step(8'h28, 1'b0, 3'd1, 8'h00);
    step(8'ha8, 1'b1, 3'd1, 8'h80);
    rd(3'd1); check(rdata[7] == 1'b1, "R3 set wins", rdata[7], 1);
    // R6: shared level 1 on sources 0 and 1
    step(8'h00, 1'b1, 3'd1, 8'hff);
    step(8'h02, 1'b1, 3'd2, 8'hfc);
    step(8'h02, 1'b0, 3'd3, 8'h00);
    check(lvl == 1, "R6 shared", lvl, 1);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] s = src;
      logic [2:0] a;
      logic       w;
      logic [7:0] d;
      if ($urandom_range(0, 3) == 0) s[$urandom_range(0, 7)] ^= 1'b1;
      w = ($urandom_range(0, 2) == 0);
      a = 3'($urandom_range(0, 7));
      d = 8'($urandom);
      if (a == 3'd2) d = d & 8'($urandom);
      step(s, w, a, d);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule